// File: doc/BRIEF.md
# Hall Commutation and Braking Controller

This block turns three digitized Hall sensor bits into six gate enables for a three-phase bridge. At each rotor position it picks one upper leg and one lower leg. The upper enables are plain on/off levels. The lower enables follow a PWM carrier, or are held fully on when the full-duty control is set.

The direction of the commutation sequence depends on three controls: run, the two-bit brake selector and the direction bit. In run mode the direction bit selects the rotation directly. When run is clear and a brake mode is chosen, the sequence is driven opposite to the direction bit, which produces reverse torque. When run and both brake bits are clear, the block is in standby and every output is off.

A current-limit comparator can cut the lower legs for the rest of the current PWM carrier period. Right after each carrier rising edge the comparator is ignored for a programmable window, so that recovery spikes cannot cause false trips. Hall codes that do not name a rotor position switch the bridge off.

Top module: `bldc_commutator`

## Requirements
- R1: Phase encoding is the same for the Hall bits and for both output vectors: bit0 = U, bit1 = V, bit2 = W. With run=1 and dir=0 (forward), the forward drive for each Hall code is given as (upper/lower):
  - 001 gives U/V
  - 011 gives U/W
  - 010 gives V/W
  - 110 gives V/U
  - 100 gives W/U
  - 101 gives W/V
- R2: With run=1 and dir=1 (reverse), each Hall code drives the forward pair with upper and lower swapped.
- R3: With run=0 and brake_sel not 00, the direction is the inverse of the dir bit: dir=0 gives the reverse mapping and dir=1 gives the forward mapping.
- R4: With run=0 and brake_sel=00 (standby), all six enables are 0 for every Hall code.
- R5: Hall codes 000 and 111 are invalid, and every enable is 0 while one of them is present.
- R6: At any time at most one upper and at most one lower enable is set, and never both enables of the same phase.
- R7: With full_duty=0, the selected lower enable is 1 only while pwm_in is 1. The upper enable does not depend on pwm_in.
- R8: With full_duty=1, the selected lower enable stays 1 while pwm_in is 0.
- R9: With blank_long=0, ilim_in is ignored on the clock edge that sees the PWM rising edge and on the following BLANK_SHORT-1 edges (24 edges in total by default). It is honoured from then on.
- R10: With blank_long=1, the ignore window spans BLANK_LONG edges (48 by default).
- R11: An honoured ilim_in trips the block. While tripped, the lower enables are 0, even after ilim_in falls. The next PWM rising edge clears the trip.
- R12: Outputs are registered one clock after their inputs, and all of them are 0 during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hall | input | 3 | Digitized Hall bits (bit0=U, bit1=V, bit2=W) |
| pwm_in | input | 1 | PWM carrier/chop signal |
| ilim_in | input | 1 | Current-limit comparator, 1 = over limit |
| run_en | input | 1 | Run (motor on) control |
| brake_sel | input | 2 | Brake mode, 00 = no braking |
| dir_rev | input | 1 | Direction bit, 1 = reverse |
| full_duty | input | 1 | Hold lower legs fully on instead of chopping |
| blank_long | input | 1 | Select the long blanking window |
| hi_en | output | 3 | Upper-arm enables |
| lo_en | output | 3 | Lower-arm enables |

## Verification
The embedded assertions check these properties on every clock:
- leg exclusivity and one-hot selection (R6);
- all outputs off in standby and on invalid Hall codes;
- lower legs off while the carrier is low and full duty is clear;
- no trip while the blanking counter is running;
- a trip persisting until a carrier rising edge.

Only the bench scenarios show:
- the exact commutation table in each direction;
- the braking inversion;
- the precise boundary cycles of the short and long blanking windows;
- the release of a trip on the next carrier edge.

// File: rtl/bldc_pkg.sv
package bldc_pkg;
    localparam int NPH = 3;
    typedef logic [NPH-1:0] phase_t;

    typedef struct packed {
        phase_t hi;
        phase_t lo;
    } drive_t;
endpackage

// File: rtl/hall_decode.sv
module hall_decode
    import bldc_pkg::*;
(
    input  phase_t hall,
    input  logic   rev,
    output phase_t hi_sel,
    output phase_t lo_sel,
    output logic   valid
);
    phase_t fwd_hi;
    phase_t fwd_lo;

    always_comb begin
        valid  = 1'b1;
        fwd_hi = '0;
        fwd_lo = '0;
        unique case (hall)
            3'b001: begin fwd_hi = 3'b001; fwd_lo = 3'b010; end
            3'b011: begin fwd_hi = 3'b001; fwd_lo = 3'b100; end
            3'b010: begin fwd_hi = 3'b010; fwd_lo = 3'b100; end
            3'b110: begin fwd_hi = 3'b010; fwd_lo = 3'b001; end
            3'b100: begin fwd_hi = 3'b100; fwd_lo = 3'b001; end
            3'b101: begin fwd_hi = 3'b100; fwd_lo = 3'b010; end
            default: valid = 1'b0;
        endcase
        hi_sel = rev ? fwd_lo : fwd_hi;
        lo_sel = rev ? fwd_hi : fwd_lo;
    end
endmodule

// File: rtl/limit_blanker.sv
module limit_blanker #(
    parameter int BLANK_SHORT = 24,
    parameter int BLANK_LONG  = 48
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwm_in,
    input  logic ilim_in,
    input  logic blank_long,
    output logic trip
);
    localparam int CNT_W = $clog2(BLANK_LONG);
    localparam logic [CNT_W-1:0] LOAD_S = CNT_W'(BLANK_SHORT - 1);
    localparam logic [CNT_W-1:0] LOAD_L = CNT_W'(BLANK_LONG - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             trip;
        logic             pwm;
    } blank_st_t;

    blank_st_t st_d, st_q;
    logic rise;

    always_comb begin
        st_d     = st_q;
        st_d.pwm = pwm_in;
        rise     = pwm_in && !st_q.pwm;
        if (rise) begin
            st_d.cnt  = blank_long ? LOAD_L : LOAD_S;
            st_d.trip = 1'b0;
        end else begin
            if (st_q.cnt != '0)
                st_d.cnt = st_q.cnt - 1'b1;
            else if (ilim_in)
                st_d.trip = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign trip = st_q.trip;

    // R9
    blank_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.cnt != '0 && !st_q.trip) |=> !st_q.trip);

    // R11
    trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.trip && !(pwm_in && !st_q.pwm)) |=> st_q.trip);
endmodule

// File: rtl/bldc_commutator.sv
module bldc_commutator
    import bldc_pkg::*;
#(
    parameter int BLANK_SHORT = 24,
    parameter int BLANK_LONG  = 48
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] hall,
    input  logic       pwm_in,
    input  logic       ilim_in,
    input  logic       run_en,
    input  logic [1:0] brake_sel,
    input  logic       dir_rev,
    input  logic       full_duty,
    input  logic       blank_long,
    output logic [2:0] hi_en,
    output logic [2:0] lo_en
);
    drive_t drv_d, drv_q;
    phase_t hi_sel, lo_sel;
    logic   valid, rev, active, chop, trip;

    assign active = run_en || (brake_sel != 2'b00);
    assign rev    = run_en ? dir_rev : !dir_rev;

    hall_decode u_dec (
        .hall   (hall),
        .rev    (rev),
        .hi_sel (hi_sel),
        .lo_sel (lo_sel),
        .valid  (valid)
    );

    limit_blanker #(
        .BLANK_SHORT (BLANK_SHORT),
        .BLANK_LONG  (BLANK_LONG)
    ) u_blank (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwm_in     (pwm_in),
        .ilim_in    (ilim_in),
        .blank_long (blank_long),
        .trip       (trip)
    );

    always_comb begin
        chop     = (full_duty || pwm_in) && !trip;
        drv_d.hi = (active && valid) ? hi_sel : '0;
        drv_d.lo = (active && valid && chop) ? lo_sel : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) drv_q <= '0;
        else        drv_q <= drv_d;
    end

    assign hi_en = drv_q.hi;
    assign lo_en = drv_q.lo;

    // R6
    leg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hi_en) && $onehot0(lo_en) && ((hi_en & lo_en) == 3'b000));

    // R4
    standby_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && brake_sel == 2'b00) |=> (hi_en == 3'b000 && lo_en == 3'b000));

    // R5
    bad_hall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hall == 3'b000 || hall == 3'b111) |=> (lo_en == 3'b000 && hi_en == 3'b000));

    // R7
    chop_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duty && !pwm_in) |=> (lo_en == 3'b000));
endmodule

// File: tb/tb_bldc_commutator.sv
module tb_bldc_commutator;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall = 3'b001;
    logic       pwm_in = 1'b0;
    logic       ilim_in = 1'b0;
    logic       run_en = 1'b0;
    logic [1:0] brake_sel = 2'b00;
    logic       dir_rev = 1'b0;
    logic       full_duty = 1'b0;
    logic       blank_long = 1'b0;
    logic [2:0] hi_en, lo_en;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    typedef struct {
        logic [2:0] hi;
        logic [2:0] lo;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    bldc_commutator dut (
        .clk(clk), .rst_n(rst_n), .hall(hall), .pwm_in(pwm_in), .ilim_in(ilim_in),
        .run_en(run_en), .brake_sel(brake_sel), .dir_rev(dir_rev),
        .full_duty(full_duty), .blank_long(blank_long), .hi_en(hi_en), .lo_en(lo_en)
    );

    function automatic logic [5:0] fwd_pair(input logic [2:0] h);
        case (h)
            3'b001: return {3'b001, 3'b010};
            3'b011: return {3'b001, 3'b100};
            3'b010: return {3'b010, 3'b100};
            3'b110: return {3'b010, 3'b001};
            3'b100: return {3'b100, 3'b001};
            3'b101: return {3'b100, 3'b010};
            default: return 6'b0;
        endcase
    endfunction

    // monitor: compares queued expectations just after the following edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            while (sb.size() > 0) begin
                exp_t e;
                e = sb.pop_front();
                checks++;
                if (hi_en !== e.hi || lo_en !== e.lo) begin
                    errors++;
                    $display("FAIL %s: hi=%b lo=%b expected hi=%b lo=%b",
                             e.tag, hi_en, lo_en, e.hi, e.lo);
                end
            end
        end
    end

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic [2:0] h, input logic [2:0] l, input string tag);
        exp_t e;
        e.hi = h; e.lo = l; e.tag = tag;
        sb.push_back(e);
        @(posedge clk);
        @(negedge clk);
    endtask

    // one ilim pulse of one cycle, sampled at edge 'start' after the PWM rise
    task automatic blank_trial(input logic lng, input int start, input logic tripped, input string tag);
        run_en = 1; brake_sel = 0; dir_rev = 0; hall = 3'b001; full_duty = 0;
        blank_long = lng; ilim_in = 0; pwm_in = 0;
        settle(4);
        pwm_in = 1;
        @(posedge clk);
        @(negedge clk);
        repeat (start - 1) @(negedge clk);
        ilim_in = 1;
        @(negedge clk);
        ilim_in = 0;
        settle(3);
        expect_out(3'b001, tripped ? 3'b000 : 3'b010, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: hi=%b lo=%b expected completion", hi_en, lo_en);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [5:0] p;
        // R12: reset state with active stimulus applied
        run_en = 1; full_duty = 1; hall = 3'b011;
        settle(3);
        checks++;
        if (hi_en !== 3'b000 || lo_en !== 3'b000) begin
            errors++;
            $display("FAIL R12: hi=%b lo=%b expected hi=000 lo=000", hi_en, lo_en);
        end
        rst_n = 1;
        settle(2);

        // R1 forward table, R8 full duty with pwm low
        pwm_in = 0; dir_rev = 0;
        for (int i = 1; i < 7; i++) begin
            hall = 3'(i);
            settle(2);
            p = fwd_pair(3'(i));
            expect_out(p[5:3], p[2:0], "R1");
            checks++;
            if ((hi_en & lo_en) != 0 || $countones(hi_en) > 1 || $countones(lo_en) > 1) begin
                errors++;
                $display("FAIL R6: hi=%b lo=%b expected disjoint single legs", hi_en, lo_en);
            end
        end
        hall = 3'b110; settle(2);
        expect_out(3'b010, 3'b001, "R8");

        // R2 reverse in run mode
        dir_rev = 1;
        for (int i = 1; i < 7; i++) begin
            hall = 3'(i);
            settle(2);
            p = fwd_pair(3'(i));
            expect_out(p[2:0], p[5:3], "R2");
        end

        // R3 braking inversion
        run_en = 0; brake_sel = 2'b01; dir_rev = 0; hall = 3'b010; settle(2);
        expect_out(3'b100, 3'b010, "R3");
        brake_sel = 2'b11; dir_rev = 1; hall = 3'b101; settle(2);
        expect_out(3'b100, 3'b010, "R3");

        // R4 standby
        brake_sel = 2'b00; hall = 3'b011; settle(2);
        expect_out(3'b000, 3'b000, "R4");
        dir_rev = 0; hall = 3'b100; settle(2);
        expect_out(3'b000, 3'b000, "R4");

        // R5 invalid Hall codes
        run_en = 1; hall = 3'b000; settle(2);
        expect_out(3'b000, 3'b000, "R5");
        hall = 3'b111; settle(2);
        expect_out(3'b000, 3'b000, "R5");

        // R7 chopping of lower leg only
        full_duty = 0; hall = 3'b001; pwm_in = 0; settle(2);
        expect_out(3'b001, 3'b000, "R7");
        pwm_in = 1; settle(2);
        expect_out(3'b001, 3'b010, "R7");

        // R9 short window boundaries
        blank_trial(1'b0, 23, 1'b0, "R9");
        blank_trial(1'b0, 24, 1'b1, "R9");
        // R10 long window boundaries
        blank_trial(1'b1, 30, 1'b0, "R10");
        blank_trial(1'b1, 47, 1'b0, "R10");
        blank_trial(1'b1, 48, 1'b1, "R10");

        // R11 trip holds until next carrier rise
        blank_trial(1'b0, 30, 1'b1, "R11");
        settle(10);
        expect_out(3'b001, 3'b000, "R11");
        full_duty = 1; settle(2);
        expect_out(3'b001, 3'b000, "R11");
        full_duty = 0;
        pwm_in = 0; settle(2);
        pwm_in = 1; settle(3);
        expect_out(3'b001, 3'b010, "R11");

        settle(2);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule